// File: doc/BRIEF.md
# SPI Controller Register Front-End

This block sits between a simple memory-mapped bus port and a serial shift engine. It holds the controller's configuration word and the transfer-complete interrupt flag. It also owns two small byte queues. The transmit queue is filled by bus writes and drained by the engine. The receive queue is filled by the engine and drained by bus reads. The engine sees the stored configuration, the head of the transmit queue and a ready flag for the receive queue. In return it reports whether it is busy and pulses a done signal when a transfer ends.

The bus port has no handshake. A request is one cycle with `bus_valid` high. The read data is combinational and belongs to the cycle in which the request is presented. Writes, queue pushes and pops take effect at the closing clock edge. Register selection uses address bits 3:2. Control is at 0x0, status at 0x4, transmit data at 0x8 and receive data at 0xC.

Top module: `spi_regfront`

## Requirements
- R1: After synchronous reset, the control word reads 0, `irq` is 0, `eng_tx_valid` is 0, `eng_rx_ready` is 1, and status reads 0x0A (both queues empty).
- R2: A control write keeps bits 0, 1, 3 to 15 and 29 to 31 as written. All other bits read back 0, including the flush bits 16 and 17. Bit 0 is enable, bit 1 is interrupt enable and bit 2 is pending.
- R3: A one-cycle `eng_done` sets pending (control bit 2). Pending is cleared by writing 1 to bit 2, and writing 0 there leaves it unchanged. When `eng_done` and a clearing write fall in the same cycle, pending ends up set.
- R4: `irq` is high exactly when the interrupt enable (bit 1) and pending (bit 2) are both set.
- R5: Status is built from live state with no storage. Bit 0 is transmit full, bit 1 transmit empty, bit 2 receive full, bit 3 receive empty and bit 4 equals `eng_busy` in the same cycle. Bits 31:5 read 0.
- R6: Each write to 0x8 pushes `bus_wdata[7:0]` into the transmit queue. `eng_tx_data` shows the oldest entry whenever `eng_tx_valid` is high. Each `eng_tx_pop` advances the queue in first-in first-out order.
- R7: The transmit queue holds 8 entries. A write to a full queue is dropped and leaves the queue contents intact.
- R8: A read of 0xC returns the oldest received byte in bits 7:0, with zeros above, and pops it. A read of 0xC while the receive queue is empty returns 0 and changes nothing.
- R9: The receive queue holds 8 entries. `eng_rx_ready` is low while it is full, and an `eng_rx_push` in that state is dropped.
- R10: A control write with bit 16 set empties the transmit queue, and one with bit 17 set empties the receive queue. A push in the same cycle as the flush is discarded.
- R11: Writes to status (0x4) or receive data (0xC) change nothing. A read of 0x8 returns 0 and does not pop the transmit queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte address, bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current request |
| eng_cfg | output | 32 | Control word as read by software |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_rx_ready | output | 1 | Receive queue has room |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_rx_push | input | 1 | Engine stores `eng_rx_data` |
| eng_busy | input | 1 | Engine is shifting |
| eng_done | input | 1 | One-cycle pulse at the end of a transfer |
| irq | output | 1 | Interrupt request |

## Verification
Read data and the status busy bit are due in the same cycle as the request. The bench therefore samples `bus_rdata` one time unit after it drives a request at a falling edge, before any rising edge can act. Writes, pushes, pops, flushes and the done pulse show up only after the next rising edge. Every task drops its strobes at the following falling edge, and the effects are checked with a fresh read there. The flush-versus-push and done-versus-clear cases put both stimuli in the same single cycle, so the priority rule decides the result.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

    localparam int WORD_W     = 32;
    localparam int REG_ADDR_W = 4;
    localparam int BYTE_W     = 8;
    localparam int Q_DEPTH    = 8;

    // control bit positions that the logic decodes
    localparam int CB_ENABLE   = 0;
    localparam int CB_INT_EN   = 1;
    localparam int CB_PEND     = 2;
    localparam int CB_TX_FLUSH = 16;
    localparam int CB_RX_FLUSH = 17;

    // bits stored verbatim from a control write
    localparam logic [WORD_W-1:0] CTRL_KEEP_MASK = 32'hE000_FFFB;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_TXD  = 2'd2,
        SEL_RXD  = 2'd3
    } reg_sel_e;

    // first field is the most significant bit
    typedef struct packed {
        logic busy;
        logic rx_empty;
        logic rx_full;
        logic tx_empty;
        logic tx_full;
    } status_t;

    typedef struct packed {
        logic ctrl_wr;
        logic tx_push;
        logic rx_pop;
    } strobes_t;

    function automatic reg_sel_e decode_sel(input logic [REG_ADDR_W-1:0] addr);
        return reg_sel_e'(addr[3:2]);
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input status_t s);
        return {{(WORD_W - $bits(status_t)){1'b0}}, s};
    endfunction

endpackage

// File: rtl/spi_regfront_fifo.sv
module spi_regfront_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/spi_regfront_ctrl.sv
module spi_regfront_ctrl
    import spi_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              hw_done,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              tx_flush,
    output logic              rx_flush,
    output logic              int_en,
    output logic              pending
);

    logic [WORD_W-1:0] keep_q;
    logic              pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q <= '0;
        end else if (wr_en) begin
            keep_q <= wdata & CTRL_KEEP_MASK;
        end
    end

    // a completing transfer outranks a same-cycle software clear
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (hw_done) begin
            pend_q <= 1'b1;
        end else if (wr_en && wdata[CB_PEND]) begin
            pend_q <= 1'b0;
        end
    end

    assign tx_flush  = wr_en && wdata[CB_TX_FLUSH];
    assign rx_flush  = wr_en && wdata[CB_RX_FLUSH];
    assign int_en    = keep_q[CB_INT_EN];
    assign pending   = pend_q;
    assign ctrl_word = keep_q | (WORD_W'(pend_q) << CB_PEND);

endmodule

// File: rtl/spi_regfront_decode.sv
module spi_regfront_decode
    import spi_regfront_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]     ctrl_word,
    input  status_t               status,
    input  logic [DATA_W-1:0]     rx_head,
    output strobes_t              strb,
    output logic [WORD_W-1:0]     rdata
);

    reg_sel_e sel;

    assign sel = decode_sel(bus_addr);

    always_comb begin
        strb         = '0;
        strb.ctrl_wr = bus_valid && bus_write && (sel == SEL_CTRL);
        strb.tx_push = bus_valid && bus_write && (sel == SEL_TXD);
        strb.rx_pop  = bus_valid && !bus_write && (sel == SEL_RXD);
    end

    always_comb begin
        rdata = '0;
        if (bus_valid && !bus_write) begin
            unique case (sel)
                SEL_CTRL: rdata = ctrl_word;
                SEL_STAT: rdata = status_word(status);
                SEL_RXD:  rdata = status.rx_empty ? '0 : WORD_W'(rx_head);
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_regfront_pkg::*;
#(
    parameter int FIFO_W     = BYTE_W,
    parameter int FIFO_DEPTH = Q_DEPTH,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [WORD_W-1:0]     eng_cfg,
    output logic                  eng_tx_valid,
    output logic [FIFO_W-1:0]     eng_tx_data,
    input  logic                  eng_tx_pop,
    output logic                  eng_rx_ready,
    input  logic [FIFO_W-1:0]     eng_rx_data,
    input  logic                  eng_rx_push,
    input  logic                  eng_busy,
    input  logic                  eng_done,
    output logic                  irq
);

    strobes_t          strb;
    status_t           status;
    logic [WORD_W-1:0] ctrl_word;
    logic              tx_flush;
    logic              rx_flush;
    logic              int_en;
    logic              pending;
    logic              tx_full;
    logic              tx_empty;
    logic              rx_full;
    logic              rx_empty;
    logic [FIFO_W-1:0] rx_head;
    logic [LVL_W-1:0]  tx_level;
    logic [LVL_W-1:0]  rx_level;

    spi_regfront_decode #(.DATA_W(FIFO_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .ctrl_word (ctrl_word),
        .status    (status),
        .rx_head   (rx_head),
        .strb      (strb),
        .rdata     (bus_rdata)
    );

    spi_regfront_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (strb.ctrl_wr),
        .wdata     (bus_wdata),
        .hw_done   (eng_done),
        .ctrl_word (ctrl_word),
        .tx_flush  (tx_flush),
        .rx_flush  (rx_flush),
        .int_en    (int_en),
        .pending   (pending)
    );

    spi_regfront_fifo #(.WIDTH(FIFO_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .push      (strb.tx_push),
        .push_data (bus_wdata[FIFO_W-1:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .full      (tx_full),
        .empty     (tx_empty),
        .level     (tx_level)
    );

    spi_regfront_fifo #(.WIDTH(FIFO_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (strb.rx_pop),
        .head      (rx_head),
        .full      (rx_full),
        .empty     (rx_empty),
        .level     (rx_level)
    );

    always_comb begin
        status.busy     = eng_busy;
        status.rx_empty = rx_empty;
        status.rx_full  = rx_full;
        status.tx_empty = tx_empty;
        status.tx_full  = tx_full;
    end

    assign eng_cfg      = ctrl_word;
    assign eng_tx_valid = !tx_empty;
    assign eng_rx_ready = !rx_full;
    assign irq          = int_en && pending;

endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk
    import spi_regfront_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_valid,
    input logic                  bus_write,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0]     bus_wdata,
    input logic [WORD_W-1:0]     bus_rdata,
    input logic                  eng_rx_push,
    input logic                  eng_busy,
    input logic                  eng_done,
    input logic                  irq,
    input logic                  pending,
    input logic [LVL_W-1:0]      tx_level,
    input logic [LVL_W-1:0]      rx_level
);

    logic rd_ctrl, rd_stat, rd_rx, wr_ctrl;

    assign rd_ctrl = bus_valid && !bus_write && (bus_addr[3:2] == 2'd0);
    assign rd_stat = bus_valid && !bus_write && (bus_addr[3:2] == 2'd1);
    assign rd_rx   = bus_valid && !bus_write && (bus_addr[3:2] == 2'd3);
    assign wr_ctrl = bus_valid && bus_write && (bus_addr[3:2] == 2'd0);

    assert_ctrl_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl |-> (bus_rdata[CB_RX_FLUSH:CB_TX_FLUSH] == 2'b00));

    assert_done_sets_pending_R3: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> pending);

    assert_irq_needs_pending_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> pending);

    assert_busy_live_R5: assert property (@(posedge clk) disable iff (rst)
        rd_stat |-> (bus_rdata[4] == eng_busy));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        tx_level <= LVL_W'(DEPTH));

    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && rx_level == '0) |-> (bus_rdata == '0));

    assert_empty_read_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && rx_level == '0 && !eng_rx_push) |=> (rx_level == '0));

    assert_rx_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LVL_W'(DEPTH));

    assert_tx_flush_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[CB_TX_FLUSH]) |=> (tx_level == '0));

    assert_rx_flush_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[CB_RX_FLUSH]) |=> (rx_level == '0));

endmodule

bind spi_regfront spi_regfront_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .eng_rx_push (eng_rx_push),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .irq         (irq),
    .pending     (pending),
    .tx_level    (tx_level),
    .rx_level    (rx_level)
);

// File: tb/spi_regfront_test.sv
module spi_regfront_test;

    localparam int HALF_PERIOD = 4; // 8 ns period, 125 MHz
    localparam int WATCHDOG    = 100000;
    localparam int NVEC        = 17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] eng_cfg;
    logic        eng_tx_valid;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_pop = 1'b0;
    logic        eng_rx_ready;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_rx_push = 1'b0;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #HALF_PERIOD clk = ~clk;

    spi_regfront uut (
        .clk          (clk),
        .rst          (rst),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .eng_cfg      (eng_cfg),
        .eng_tx_valid (eng_tx_valid),
        .eng_tx_data  (eng_tx_data),
        .eng_tx_pop   (eng_tx_pop),
        .eng_rx_ready (eng_rx_ready),
        .eng_rx_data  (eng_rx_data),
        .eng_rx_push  (eng_rx_push),
        .eng_busy     (eng_busy),
        .eng_done     (eng_done),
        .irq          (irq)
    );

    // {is_read, addr, wdata, expected read data}
    localparam logic [68:0] VEC [NVEC] = '{
        {1'b0, 4'h0, 32'hFFFF_FFFF, 32'h0},          // R2 all ones
        {1'b1, 4'h0, 32'h0,         32'hE000_FFFB},  // R2 mask
        {1'b1, 4'h4, 32'h0,         32'h0000_000A},  // R5 idle status
        {1'b0, 4'h0, 32'h0,         32'h0},
        {1'b1, 4'h0, 32'h0,         32'h0},          // R2 zeros
        {1'b0, 4'h0, 32'h0000_A5A9, 32'h0},
        {1'b1, 4'h0, 32'h0,         32'h0000_A5A9},  // R2 pattern
        {1'b0, 4'h8, 32'h1234_56AB, 32'h0},          // R6 push
        {1'b0, 4'h8, 32'h0000_00CD, 32'h0},
        {1'b1, 4'h4, 32'h0,         32'h0000_0008},  // R5 tx not empty
        {1'b1, 4'h8, 32'h0,         32'h0},          // R11 tx reads 0
        {1'b1, 4'hC, 32'h0,         32'h0},          // R8 empty rx read
        {1'b0, 4'h4, 32'hFFFF_FFFF, 32'h0},          // R11 status write
        {1'b1, 4'h4, 32'h0,         32'h0000_0008},
        {1'b0, 4'h0, 32'h0003_0000, 32'h0},          // R10 flush both
        {1'b1, 4'h0, 32'h0,         32'h0},
        {1'b1, 4'h4, 32'h0,         32'h0000_000A}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic tx_pop();
        @(negedge clk); eng_tx_pop = 1'b1;
        @(negedge clk); eng_tx_pop = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk); eng_rx_push = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 tx_valid", {31'd0, eng_tx_valid}, 32'd0);
        check("R1 rx_ready", {31'd0, eng_rx_ready}, 32'd1);
        check("R1 cfg", eng_cfg, 32'd0);
        rd_check("R1 status", 4'h4, 32'h0000_000A);
        rd_check("R1 ctrl", 4'h0, 32'h0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [68:0] v;
            logic [31:0] d;
            v = VEC[i];
            if (v[68]) begin
                bus_rd(v[67:64], d);
                check($sformatf("table entry %0d", i), d, v[31:0]);
            end else begin
                bus_wr(v[67:64], v[63:32]);
            end
        end

        // R6 order
        bus_wr(4'h8, 32'hFFFF_FF11);
        bus_wr(4'h8, 32'h22);
        bus_wr(4'h8, 32'h33);
        #1;
        check("R6 valid", {31'd0, eng_tx_valid}, 32'd1);
        check("R6 head0", {24'd0, eng_tx_data}, 32'h11);
        tx_pop(); #1;
        check("R6 head1", {24'd0, eng_tx_data}, 32'h22);
        tx_pop(); #1;
        check("R6 head2", {24'd0, eng_tx_data}, 32'h33);
        rd_check("R11 tx read no pop", 4'h8, 32'h0);
        #1 check("R11 head kept", {24'd0, eng_tx_data}, 32'h33);
        tx_pop(); #1;
        check("R6 drained", {31'd0, eng_tx_valid}, 32'd0);
        tx_pop(); // pop while empty: ignored

        // R7 overflow
        for (int i = 0; i < 8; i++) bus_wr(4'h8, 32'(i + 8'h60));
        bus_wr(4'h8, 32'hEE);
        rd_check("R7 full status", 4'h4, 32'h0000_0009);
        for (int i = 0; i < 8; i++) begin
            #1 check("R7 order", {24'd0, eng_tx_data}, 32'(i + 8'h60));
            tx_pop();
        end
        #1 check("R7 dropped", {31'd0, eng_tx_valid}, 32'd0);

        // R8 receive reads
        rx_push(8'h5A);
        rx_push(8'hA5);
        rd_check("R8 first", 4'hC, 32'h5A);
        rd_check("R8 second", 4'hC, 32'hA5);
        rd_check("R8 empty", 4'hC, 32'h0);
        rd_check("R8 empty status", 4'h4, 32'h0000_000A);
        rx_push(8'h77);
        rd_check("R8 pointers kept", 4'hC, 32'h77);

        // R9 receive full
        for (int i = 0; i < 9; i++) rx_push(8'(i + 8'h40));
        #1 check("R9 ready low", {31'd0, eng_rx_ready}, 32'd0);
        rd_check("R9 full status", 4'h4, 32'h0000_0006);
        for (int i = 0; i < 8; i++) rd_check("R9 drain", 4'hC, 32'(i + 8'h40));
        rd_check("R9 dropped", 4'hC, 32'h0);

        // R10 flush beats same-cycle push
        rx_push(8'h01);
        rx_push(8'h02);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0002_0000;
        eng_rx_push = 1'b1; eng_rx_data = 8'h03;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; eng_rx_push = 1'b0;
        rd_check("R10 rx flushed", 4'h4, 32'h0000_000A);
        rd_check("R10 bit reads 0", 4'h0, 32'h0);
        bus_wr(4'h8, 32'h44);
        bus_wr(4'h0, 32'h0001_0000);
        #1 check("R10 tx flushed", {31'd0, eng_tx_valid}, 32'd0);

        // R11 write to receive data
        rx_push(8'h99);
        bus_wr(4'hC, 32'h0000_00FF);
        rd_check("R11 rx write ignored", 4'hC, 32'h99);
        rd_check("R11 rx now empty", 4'hC, 32'h0);

        // R3 / R4 pending and interrupt
        bus_wr(4'h0, 32'h2);
        done_pulse();
        rd_check("R3 set", 4'h0, 32'h6);
        #1 check("R4 irq on", {31'd0, irq}, 32'd1);
        bus_wr(4'h0, 32'h2);
        rd_check("R3 write0 no effect", 4'h0, 32'h6);
        bus_wr(4'h0, 32'h6);
        rd_check("R3 cleared", 4'h0, 32'h2);
        #1 check("R4 irq off", {31'd0, irq}, 32'd0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h6;
        eng_done = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; eng_done = 1'b0;
        rd_check("R3 set wins", 4'h0, 32'h6);
        bus_wr(4'h0, 32'h0);
        rd_check("R4 pending kept", 4'h0, 32'h4);
        #1 check("R4 masked", {31'd0, irq}, 32'd0);
        check("R2 cfg out", eng_cfg, 32'h4);

        // R5 busy live
        @(negedge clk) eng_busy = 1'b1;
        rd_check("R5 busy", 4'h4, 32'h0000_001A);
        @(negedge clk) eng_busy = 1'b0;
        rd_check("R5 idle", 4'h4, 32'h0000_000A);

        done_flag = 1'b1;
        summary();
        $finish;
    end

endmodule